// File: doc/BRIEF.md
# Hardware Alarm Comparator on a Byte-Wide I/O Bus

This peripheral hangs off the 6-bit I/O address bus of a small processor. Software loads a 16-bit packed-BCD alarm time (hours in the high byte, minutes in the low byte) through two byte-wide write addresses. It reads the running time of day, which an external counter supplies, through two other addresses. The same decoder also serves an 8-bit switch port, a second 8-bit input port and an 8-bit LED output register.

The comparison between the alarm time and the current time runs in hardware on every clock, so no match is lost to software polling. A three-state sequencer (Off, Armed, Ringing) catches the result. The sequencer advances only on cycles where a timebase enable is high, so it can follow a slow tick while running on the system clock. It is armed by a key input. It rings on an exact match and keeps ringing after the match minute has passed, until the key is released. While it rings, the LED outputs are forced to all ones.

Top module: `alarm_io_periph`

## Requirements
- R1: After synchronous reset the sequencer is Off (ring = 0), the LED register is 0x00 and the alarm register is 0x0000.
- R2: A write to address 0x18 loads the alarm minutes byte and a write to address 0x17 loads the alarm hours byte. Writes to any other address leave the alarm register unchanged.
- R3: While io_rd = 1, io_rdata returns: the switches at 0x19, the auxiliary input port at 0x16, the current-time hours byte at 0x05, the current-time minutes byte at 0x04, and 0xAA at every other address. While io_rd = 0, io_rdata is 0x00.
- R4: A write to address 0x1B loads the 8-bit LED register.
- R5: The sequencer changes state only at clock edges where tick_en = 1.
- R6: From Off, a tick with arm_key = 1 moves to Armed, even if the times already match. A tick with arm_key = 0 stays in Off.
- R7: From Armed, a tick with arm_key = 1 and the alarm equal to time_now moves to Ringing.
- R8: A tick with arm_key = 0 returns Armed or Ringing to Off. This takes priority over a match.
- R9: ring is 1 exactly in Ringing. Ringing persists on ticks after the equality ends, as long as arm_key = 1.
- R10: While ring = 1, led_out is 0xFF. Otherwise led_out is the LED register.
- R11: Equality is a full 16-bit compare: a difference in only the hours byte or only the minutes digit does not ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 6 | I/O address from the processor |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data (combinational) |
| sw_in | input | 8 | Switch port |
| aux_in | input | 8 | Auxiliary input port |
| time_now | input | 16 | Current time, packed BCD HHMM |
| arm_key | input | 1 | Arm key, 1 = armed |
| tick_en | input | 1 | Timebase enable for the sequencer |
| led_out | output | 8 | LED outputs |
| ring | output | 1 | Alarm ringing |

## Verification
The bench sets a match while the sequencer is Off. A design that jumps from Off straight to Ringing, or that lets a match override a released key, rings at that point. It presents times that differ from the alarm only in the hours byte or only in one minutes digit; a partial compare rings early. It holds a match with tick_en low for several clocks; a design that ignores the enable rings early. It then moves the time on past the match; a design that drops out of Ringing when the match ends shows ring falling. A write to the auxiliary address between the alarm writes and the match catches a decoder that aliases the alarm bytes, and the read table catches wrong or missing 0xAA fill values.

// File: rtl/alarm_io_pkg.sv
package alarm_io_pkg;

    localparam int unsigned IO_AW = 6;
    localparam int unsigned IO_DW = 8;
    localparam int unsigned HHMM_W = 2 * IO_DW;

    // I/O map; the processor firmware depends on these values
    localparam logic [IO_AW-1:0] A_ALM_MIN  = IO_AW'(6'h18);
    localparam logic [IO_AW-1:0] A_ALM_HR   = IO_AW'(6'h17);
    localparam logic [IO_AW-1:0] A_NOW_HR   = IO_AW'(6'h05);
    localparam logic [IO_AW-1:0] A_NOW_MIN  = IO_AW'(6'h04);
    localparam logic [IO_AW-1:0] A_SWITCH   = IO_AW'(6'h19);
    localparam logic [IO_AW-1:0] A_AUXPORT  = IO_AW'(6'h16);
    localparam logic [IO_AW-1:0] A_LEDREG   = IO_AW'(6'h1B);

    localparam logic [IO_DW-1:0] RD_FILL    = IO_DW'(8'hAA);

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RING  = 2'd2
    } alm_state_e;

    typedef struct packed {
        logic [IO_DW-1:0] hr;
        logic [IO_DW-1:0] mn;
    } hhmm_t;

    function automatic alm_state_e alm_next(alm_state_e cur, logic key, logic hit);
        alm_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_OFF:   if (key) nxt = ST_ARMED;
            ST_ARMED: if (!key) nxt = ST_OFF;
                      else if (hit) nxt = ST_RING;
            ST_RING:  if (!key) nxt = ST_OFF;
            default:  nxt = ST_OFF;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/alarm_io_wrregs.sv
module alarm_io_wrregs
    import alarm_io_pkg::*;
#(
    parameter int unsigned AW = IO_AW,
    parameter int unsigned DW = IO_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output hhmm_t         alarm_q,
    output logic [DW-1:0] led_q
);
    localparam int unsigned NLANE = 2;

    logic [DW-1:0] lane_q [NLANE];

    // lane 0 = minutes, lane 1 = hours
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam logic [AW-1:0] LANE_ADDR = (g == 0) ? A_ALM_MIN : A_ALM_HR;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (wr && addr == LANE_ADDR) begin
                lane_q[g] <= wdata;
            end
        end
    end

    assign alarm_q.mn = lane_q[0];
    assign alarm_q.hr = lane_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= '0;
        end else if (wr && addr == A_LEDREG) begin
            led_q <= wdata;
        end
    end

endmodule

// File: rtl/alarm_io_rdmux.sv
module alarm_io_rdmux
    import alarm_io_pkg::*;
#(
    parameter int unsigned AW = IO_AW,
    parameter int unsigned DW = IO_DW
) (
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] sw_in,
    input  logic [DW-1:0] aux_in,
    input  hhmm_t         now,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                A_SWITCH:  rdata = sw_in;
                A_AUXPORT: rdata = aux_in;
                A_NOW_HR:  rdata = now.hr;
                A_NOW_MIN: rdata = now.mn;
                default:   rdata = RD_FILL;
            endcase
        end
    end

endmodule

// File: rtl/alarm_io_seq.sv
module alarm_io_seq
    import alarm_io_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_en,
    input  logic  arm_key,
    input  hhmm_t alarm,
    input  hhmm_t now,
    output logic  ring
);
    alm_state_e state_q;
    logic       hit;

    // full-width compare, evaluated every clock
    assign hit = (alarm == now);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
        end else if (tick_en) begin
            state_q <= alm_next(state_q, arm_key, hit);
        end
    end

    assign ring = (state_q == ST_RING);

endmodule

// File: rtl/alarm_io_periph.sv
module alarm_io_periph
    import alarm_io_pkg::*;
#(
    parameter int unsigned AW = IO_AW,
    parameter int unsigned DW = IO_DW,
    localparam int unsigned TW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic [DW-1:0] io_wdata,
    input  logic          io_wr,
    input  logic          io_rd,
    output logic [DW-1:0] io_rdata,
    input  logic [DW-1:0] sw_in,
    input  logic [DW-1:0] aux_in,
    input  logic [TW-1:0] time_now,
    input  logic          arm_key,
    input  logic          tick_en,
    output logic [DW-1:0] led_out,
    output logic          ring
);
    hhmm_t         alarm_q;
    hhmm_t         now_s;
    logic [DW-1:0] led_q;

    assign now_s = hhmm_t'(time_now);

    alarm_io_wrregs #(.AW(AW), .DW(DW)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr      (io_wr),
        .addr    (io_addr),
        .wdata   (io_wdata),
        .alarm_q (alarm_q),
        .led_q   (led_q)
    );

    alarm_io_rdmux #(.AW(AW), .DW(DW)) u_rd (
        .rd     (io_rd),
        .addr   (io_addr),
        .sw_in  (sw_in),
        .aux_in (aux_in),
        .now    (now_s),
        .rdata  (io_rdata)
    );

    alarm_io_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .arm_key (arm_key),
        .alarm   (alarm_q),
        .now     (now_s),
        .ring    (ring)
    );

    assign led_out = ring ? '1 : led_q;

endmodule

// File: rtl/alarm_io_chk.sv
module alarm_io_chk
    import alarm_io_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IO_AW-1:0]  io_addr,
    input logic              io_rd,
    input logic [IO_DW-1:0]  io_rdata,
    input logic              tick_en,
    input logic              arm_key,
    input logic              ring,
    input logic [IO_DW-1:0]  led_out,
    input hhmm_t             alarm_q,
    input logic [HHMM_W-1:0] time_now
);
    logic unmapped;
    assign unmapped = (io_addr != A_SWITCH) && (io_addr != A_AUXPORT) &&
                      (io_addr != A_NOW_HR) && (io_addr != A_NOW_MIN);

    a_r3_fill_unmapped: assert property (@(posedge clk) disable iff (rst)
        io_rd && unmapped |-> io_rdata == RD_FILL);

    a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> io_rdata == '0);

    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(ring));

    a_r8_key_release_off: assert property (@(posedge clk) disable iff (rst)
        tick_en && !arm_key |=> !ring);

    a_r7_ring_needs_match: assert property (@(posedge clk) disable iff (rst)
        $rose(ring) |-> $past(tick_en && arm_key && (alarm_q == time_now)));

    a_r10_led_forced: assert property (@(posedge clk) disable iff (rst)
        ring |-> led_out == '1);

endmodule

bind alarm_io_periph alarm_io_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .tick_en  (tick_en),
    .arm_key  (arm_key),
    .ring     (ring),
    .led_out  (led_out),
    .alarm_q  (alarm_q),
    .time_now (time_now)
);

// File: tb/test_alarm_io_periph.sv
module test_alarm_io_periph;
    localparam int CLK_P = 10;
    localparam int NRD = 9;
    // {address[13:8], expected read data[7:0]} with sw=5C aux=3E time=1947
    localparam logic [13:0] RD_VEC [NRD] = '{
        {6'h19, 8'h5C}, {6'h16, 8'h3E}, {6'h05, 8'h19}, {6'h04, 8'h47},
        {6'h18, 8'hAA}, {6'h17, 8'hAA}, {6'h1B, 8'hAA}, {6'h00, 8'hAA},
        {6'h3F, 8'hAA}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic [5:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 0;
    logic        io_rd = 0;
    logic [7:0]  io_rdata;
    logic [7:0]  sw_in = '0;
    logic [7:0]  aux_in = '0;
    logic [15:0] time_now = '0;
    logic        arm_key = 0;
    logic        tick_en = 0;
    logic [7:0]  led_out;
    logic        ring;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    alarm_io_periph i_alarm_io_periph (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .sw_in(sw_in),
        .aux_in(aux_in), .time_now(time_now), .arm_key(arm_key),
        .tick_en(tick_en), .led_out(led_out), .ring(ring)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all drives happen at the falling edge
    task automatic io_write(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_en = 1;
        @(negedge clk);
        tick_en = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ring", 16'(ring), 16'h0);
        check("R1 led", 16'(led_out), 16'h00);
        check("R3 idle rdata", 16'(io_rdata), 16'h00);

        // R1 alarm resets to 0000: arm then match time 0000
        arm_key = 1;
        do_tick();
        check("R6 off->armed no ring", 16'(ring), 16'h0);
        do_tick();
        check("R1/R7 ring on reset alarm", 16'(ring), 16'h1);
        check("R10 led forced", 16'(led_out), 16'hFF);
        arm_key = 0;
        idle(3);
        check("R5 no tick hold", 16'(ring), 16'h1);
        do_tick();
        check("R8 ringing->off", 16'(ring), 16'h0);
        check("R10 led restored", 16'(led_out), 16'h00);

        io_write(6'h1B, 8'hA5);
        check("R4 led write", 16'(led_out), 16'hA5);

        io_write(6'h17, 8'h07);
        io_write(6'h18, 8'h30);
        io_write(6'h16, 8'hFF);
        time_now = 16'h0730;
        do_tick();
        check("R6 off stays off key0", 16'(ring), 16'h0);
        arm_key = 1;
        time_now = 16'h0000;
        do_tick();
        time_now = 16'h0830;
        do_tick();
        check("R11 hour differs", 16'(ring), 16'h0);
        time_now = 16'h0731;
        do_tick();
        check("R11 minute differs", 16'(ring), 16'h0);
        time_now = 16'h0730;
        idle(4);
        check("R5 match without tick", 16'(ring), 16'h0);
        do_tick();
        check("R2/R7 ring at match", 16'(ring), 16'h1);
        time_now = 16'h0731;
        do_tick();
        do_tick();
        check("R9 ringing persists", 16'(ring), 16'h1);
        check("R10 led forced over A5", 16'(led_out), 16'hFF);
        arm_key = 0;
        do_tick();
        check("R8 key release", 16'(ring), 16'h0);
        check("R10 led back to A5", 16'(led_out), 16'hA5);

        // R8 priority: key 0 beats match while armed
        arm_key = 1;
        do_tick();
        time_now = 16'h0730;
        arm_key = 0;
        do_tick();
        check("R8 key0 over match", 16'(ring), 16'h0);
        arm_key = 1;
        do_tick();
        check("R6 off->armed despite match", 16'(ring), 16'h0);
        do_tick();
        check("R7 armed->ringing", 16'(ring), 16'h1);
        arm_key = 0;
        do_tick();

        // R3 read map walk
        sw_in = 8'h5C; aux_in = 8'h3E; time_now = 16'h1947;
        for (int k = 0; k < NRD; k++) begin
            @(negedge clk);
            io_addr = RD_VEC[k][13:8];
            io_rd = 1;
            #1;
            check("R3 read map", 16'(io_rdata), 16'(RD_VEC[k][7:0]));
        end
        @(negedge clk);
        io_rd = 0;
        #1;
        check("R3 rd low", 16'(io_rdata), 16'h00);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule